// File: doc/BRIEF.md
# Timer Input Capture Unit

This block watches an external input pin and, when a chosen event occurs on it, stores the current value of a free-running 16-bit timer in a capture register. The pin is resynchronised to the system clock and edge-detected. A 4-bit mode input selects the event: a falling edge, a rising edge, every fourth rising edge or every sixteenth rising edge. All other codes turn capture off. Each capture, and each direct switch between two capture modes, sets a sticky flag that software clears with a one-cycle strobe.

The two timer values enter as plain buses, and a select input chooses which one is sampled. Capture timing is only meaningful when that timer counts in step with the system clock.

The edge prescaler is cleared only while capture is off. Moving straight from one divide setting to another keeps the partial count, so the first capture after such a change can come early.

Top module: `tmr_capture`

## Requirements
- R1: On a capture event the 16-bit output `cap_value` takes the value of the selected timer bus, and `cap_flag` is set on the same clock edge.
- R2: With mode 4'b0101, a rising edge on `pin_in` causes a capture, and a falling edge does not.
- R3: With mode 4'b0100, a falling edge on `pin_in` causes a capture, and a rising edge does not.
- R4: After reset `cap_value` is 0 and `cap_flag` is 0. Once set, the flag stays set until a cycle with `flag_clr` high, which clears it.
- R5: A second capture overwrites the stored value whether or not the first one was ever cleared.
- R6: With mode 4'b0110, every fourth rising edge causes a capture, and the three edges before it do not.
- R7: With mode 4'b0111, every sixteenth rising edge causes a capture, and the fifteen edges before it do not.
- R8: `timer_sel` = 0 selects `timer_a` and `timer_sel` = 1 selects `timer_b`.
- R9: Any mode outside 4'b0100 to 4'b0111 disables capture: edges change neither output, and the edge prescaler is held at zero.
- R10: Moving directly between the two divide modes keeps the prescaler count. If the count is already at or past the new limit, the next rising edge causes a capture.
- R11: A change of mode from one capture code to a different capture code sets `cap_flag` without changing `cap_value`. Passing through a disabled code first does not set the flag.
- R12: When `flag_clr` and a capture fall in the same cycle, the capture wins and `cap_flag` stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous capture input pin |
| mode | input | 4 | Event select; 0100 fall, 0101 rise, 0110 every 4th rise, 0111 every 16th rise, other codes off |
| timer_a | input | 16 | Value of the first timer |
| timer_b | input | 16 | Value of the second timer |
| timer_sel | input | 1 | Timer source select, 0 for `timer_a` and 1 for `timer_b` |
| flag_clr | input | 1 | One-cycle strobe that clears the flag |
| cap_value | output | 16 | Most recently captured timer value |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
The hardest state to reach from the ports is a prescaler that holds a stale partial count after a direct switch from divide-by-16 to divide-by-4. The stimulus leaves ten edges in the count and then switches modes. It then clears the spurious flag raised by the switch and shows that a single further edge causes a capture. A second hard case is a clear strobe that lands on the same cycle as a capture. The bench reaches it by counting the pipeline stages from the pin change and raising `flag_clr` exactly two falling edges later.

// File: rtl/tmr_capture_pkg.sv
// Shared encodings for the timer input capture unit.
// Assumes the mode field is 4 bits wide and uses the 01xx range for capture.
package tmr_capture_pkg;

    typedef enum logic [3:0] {
        CAP_FALL   = 4'b0100,
        CAP_RISE   = 4'b0101,
        CAP_RISE4  = 4'b0110,
        CAP_RISE16 = 4'b0111
    } cap_mode_e;

    // True when the code selects one of the four capture events.
    function automatic logic mode_active(input logic [3:0] m);
        return (m[3:2] == 2'b01);
    endfunction

    // True when the code selects one of the two divided rising-edge events.
    function automatic logic mode_divided(input logic [3:0] m);
        return (m[3:1] == 3'b011);
    endfunction

endpackage

// File: rtl/cap_pin_sync.sv
// Resynchronises an asynchronous pin and reports its edges.
// Assumes the pin is held low through reset. Reports one-cycle rise/fall
// pulses by comparing the synchronised sample with the previous one.
module cap_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise,
    output logic fall
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Shift the pin through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-2:0], pin_async};
    end

    assign rise =  chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];
    assign fall = ~chain_q[CHAIN_W-2] &  chain_q[CHAIN_W-1];
endmodule

// File: rtl/cap_edge_prescaler.sv
// Counts rising edges and fires on every 4th or every 16th one.
// Assumes clear is high whenever capture is off. The count is not reset
// when the divide setting changes, so a count left over from the larger
// divide makes the next edge fire at once.
module cap_edge_prescaler #(
    parameter int SMALL_DIV = 4,
    parameter int LARGE_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step_en,
    input  logic use_large,
    input  logic rise,
    output logic fire
);
    localparam int CNT_W = $clog2(LARGE_DIV);
    localparam int CMP_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CMP_W-1:0] next_cnt;
    logic [CMP_W-1:0] limit;

    assign limit    = use_large ? CMP_W'(LARGE_DIV) : CMP_W'(SMALL_DIV);
    assign next_cnt = {1'b0, cnt_q} + CMP_W'(1);
    assign fire     = step_en & rise & (next_cnt >= limit);

    // Advance on each counted edge, wrap on fire, clear while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (fire)       cnt_q <= '0;
        else if (step_en && rise) cnt_q <= next_cnt[CNT_W-1:0];
    end
endmodule

// File: rtl/tmr_capture.sv
// Top of the timer input capture unit: selects the event from the mode
// field, copies the chosen timer into the capture register and keeps a
// sticky flag. Assumes the selected timer is synchronous to clk.
module tmr_capture
    import tmr_capture_pkg::*;
#(
    parameter int TMR_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic [3:0]       mode,
    input  logic [TMR_W-1:0] timer_a,
    input  logic [TMR_W-1:0] timer_b,
    input  logic             timer_sel,
    input  logic             flag_clr,
    output logic [TMR_W-1:0] cap_value,
    output logic             cap_flag
);
    logic       rise, fall, psc_fire, cap_evt, mode_hop, active;
    logic [3:0] mode_q;

    assign active = mode_active(mode);

    cap_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_in),
        .rise(rise), .fall(fall)
    );

    cap_edge_prescaler #(.SMALL_DIV(4), .LARGE_DIV(16)) u_psc (
        .clk(clk), .rst_n(rst_n), .clear(!active),
        .step_en(mode_divided(mode)), .use_large(mode[0]),
        .rise(rise), .fire(psc_fire)
    );

    // Pick the event that the current mode listens to.
    always_comb begin
        unique case (mode)
            CAP_FALL:           cap_evt = fall;
            CAP_RISE:           cap_evt = rise;
            CAP_RISE4, CAP_RISE16: cap_evt = psc_fire;
            default:            cap_evt = 1'b0;
        endcase
    end

    // A move between two different capture codes raises a false flag.
    assign mode_hop = active && mode_active(mode_q) && (mode != mode_q);

    // Remember the previous mode to detect direct changes.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode;
    end

    // Load the selected timer on each capture event.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_value <= '0;
        else if (cap_evt) cap_value <= timer_sel ? timer_b : timer_a;
    end

    // Sticky flag: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                cap_flag <= 1'b0;
        else if (cap_evt || mode_hop) cap_flag <= 1'b1;
        else if (flag_clr)         cap_flag <= 1'b0;
    end
endmodule

// File: rtl/tmr_capture_chk.sv
// Property checker for tmr_capture, attached by bind below.
module tmr_capture_chk #(
    parameter int TMR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       mode,
    input logic             flag_clr,
    input logic [TMR_W-1:0] cap_value,
    input logic             cap_flag,
    input logic             cap_evt,
    input logic [3:0]       psc_cnt
);
    logic en;
    assign en = (mode[3:2] == 2'b01);

    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && !flag_clr) |=> cap_flag);

    a_r9_off_holds_value: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cap_value));

    a_r9_off_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (psc_cnt == 4'd0));

    a_r1_value_change_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_value) |-> cap_flag);

    a_r12_capture_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_flag);
endmodule

bind tmr_capture tmr_capture_chk #(.TMR_W(TMR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .flag_clr(flag_clr),
    .cap_value(cap_value), .cap_flag(cap_flag), .cap_evt(cap_evt),
    .psc_cnt(u_psc.cnt_q)
);

// File: tb/tmr_capture_tb.sv
module tmr_capture_tb;
    logic        clk = 0, rst_n = 0, pin_in = 0, timer_sel = 0, flag_clr = 0;
    logic [3:0]  mode = 4'b0000;
    logic [15:0] timer_a = 16'h0, timer_b = 16'h0;
    logic [15:0] cap_value;
    logic        cap_flag;

    int checks = 0, errors = 0;
    bit done = 0;

    typedef struct { string req; logic [15:0] val; logic flag; } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    tmr_capture u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .mode(mode),
        .timer_a(timer_a), .timer_b(timer_b), .timer_sel(timer_sel),
        .flag_clr(flag_clr), .cap_value(cap_value), .cap_flag(cap_flag)
    );

    // Monitor: pop expected items and compare with the outputs.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (cap_value !== e.val || cap_flag !== e.flag) begin
                errors++;
                $display("FAIL %s: got value=%h flag=%b, expected value=%h flag=%b",
                         e.req, cap_value, cap_flag, e.val, e.flag);
            end
        end
    end

    task automatic expect_out(input string req, input logic [15:0] v, input logic f);
        exp_t e;
        e.req = req; e.val = v; e.flag = f;
        exp_q.push_back(e);
        repeat (2) @(negedge clk);
    endtask

    task automatic set_pin(input logic v);
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic rise_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            set_pin(1'b1);
            set_pin(1'b0);
        end
    endtask

    task automatic set_mode(input logic [3:0] m);
        mode = m;
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_flag();
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        expect_out("R4 reset state", 16'h0000, 1'b0);

        // Rising-edge mode
        set_mode(4'b0101);
        timer_a = 16'h1111;
        set_pin(1'b1);
        expect_out("R1 R2 rise capture", 16'h1111, 1'b1);
        repeat (10) @(negedge clk);
        expect_out("R4 flag held", 16'h1111, 1'b1);
        clear_flag();
        expect_out("R4 flag cleared", 16'h1111, 1'b0);
        set_pin(1'b0);
        expect_out("R2 fall ignored", 16'h1111, 1'b0);

        // Direct switch to falling mode: spurious flag
        set_mode(4'b0100);
        expect_out("R11 hop sets flag", 16'h1111, 1'b1);
        clear_flag();
        timer_a = 16'h2222;
        set_pin(1'b1);
        expect_out("R3 rise ignored", 16'h1111, 1'b0);
        set_pin(1'b0);
        expect_out("R3 fall capture", 16'h2222, 1'b1);
        clear_flag();

        // Overwrite
        set_mode(4'b0000);
        set_mode(4'b0101);
        expect_out("R11 via off no flag", 16'h2222, 1'b0);
        timer_a = 16'h3333;
        rise_pulse(1);
        timer_a = 16'h4444;
        set_pin(1'b1);
        expect_out("R5 overwrite", 16'h4444, 1'b1);
        clear_flag();
        set_pin(1'b0);

        // Timer select
        timer_sel = 1; timer_b = 16'h5555;
        rise_pulse(1);
        expect_out("R8 timer_b", 16'h5555, 1'b1);
        clear_flag();
        timer_sel = 0;

        // Divide by 4
        set_mode(4'b0000);
        set_mode(4'b0110);
        timer_a = 16'h6666;
        rise_pulse(3);
        expect_out("R6 three edges idle", 16'h5555, 1'b0);
        rise_pulse(1);
        expect_out("R6 fourth edge", 16'h6666, 1'b1);
        clear_flag();

        // Divide by 16
        set_mode(4'b0000);
        set_mode(4'b0111);
        timer_a = 16'h7777;
        rise_pulse(15);
        expect_out("R7 fifteen edges idle", 16'h6666, 1'b0);
        rise_pulse(1);
        expect_out("R7 sixteenth edge", 16'h7777, 1'b1);
        clear_flag();

        // Disabled mode and prescaler clear
        set_mode(4'b0000);
        timer_a = 16'h8888;
        rise_pulse(3);
        expect_out("R9 off ignores edges", 16'h7777, 1'b0);
        set_mode(4'b0110);
        rise_pulse(2);
        set_mode(4'b0000);
        set_mode(4'b0110);
        rise_pulse(3);
        expect_out("R9 count cleared", 16'h7777, 1'b0);
        rise_pulse(1);
        expect_out("R9 fourth after clear", 16'h8888, 1'b1);
        clear_flag();

        // Stale count kept across direct prescale change
        set_mode(4'b0000);
        set_mode(4'b0111);
        timer_a = 16'h9999;
        rise_pulse(10);
        expect_out("R10 ten edges idle", 16'h8888, 1'b0);
        set_mode(4'b0110);
        expect_out("R11 prescale hop flag", 16'h8888, 1'b1);
        clear_flag();
        expect_out("R10 flag cleared", 16'h8888, 1'b0);
        timer_a = 16'hAAAA;
        rise_pulse(1);
        expect_out("R10 early capture", 16'hAAAA, 1'b1);
        clear_flag();

        // Clear and capture in the same cycle
        set_mode(4'b0000);
        set_mode(4'b0101);
        timer_a = 16'hBBBB;
        pin_in = 1;
        repeat (2) @(negedge clk);
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
        repeat (2) @(negedge clk);
        expect_out("R12 capture beats clear", 16'hBBBB, 1'b1);

        repeat (4) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule